// File: doc/BRIEF.md
# Prescaled Cycle Counter

This block is a wide free-running cycle counter for a performance monitoring unit. A small control register, written over a simple write strobe, sets how it counts. It can count every clock or once per 64 clocks, and the prescaler is switched off whenever long mode is selected. Long mode also decides whether overflow is reported at the wrap of the lower half or only at the wrap of the full width. A write-only bit clears the counter.

Counting needs two things: the enable bit in the control register and a per-counter enable input. A third bit lets an external prohibit condition or a freeze condition halt the counter. When that bit is clear, those two conditions are ignored. Every overflow sets a sticky flag, which stays high until a dedicated clear strobe is pulsed. The counter value, the flag and the control readback all come straight from registers.

Control field positions are bit 0 enable, bit 1 divide-by-64, bit 2 long mode, bit 3 halt-when-prohibited, and bit 4 counter clear. Bit 4 is write-only.

Top module: `cycle_tally`

## Requirements
- R1: With enable (ctl bit 0) set, the per-counter enable input high, divide-by-64 (bit 1) clear and long mode (bit 2) clear, the counter rises by exactly one on every clock edge.
- R2: With divide-by-64 set and long mode clear, the counter rises once per 64 enabled clocks. After a clear, the first rise happens on the 64th enabled edge.
- R3: With long mode set, the divide-by-64 bit is ignored and the counter rises on every enabled clock.
- R4: With long mode clear, the overflow flag is set on the increment that takes the lower SHORT_W bits from all ones to zero.
- R5: With long mode set, a wrap of the lower SHORT_W bits alone leaves the flag unchanged. The flag is set only on the increment that takes all CNT_W bits from all ones to zero.
- R6: A control write with bit 4 set clears every counter bit and the 6-bit prescale divider on that edge, whatever long mode is set to. It leaves the overflow flag unchanged. Bit 4 always reads back as 0, and bits 3..0 read back as they were written.
- R7: With halt-when-prohibited (bit 3) set, the counter holds while the prohibit input or the freeze input is high. With bit 3 clear, neither input has any effect on counting.
- R8: The counter holds unless both the enable bit and the per-counter enable input are set.
- R9: While counting is disabled, the prescale divider keeps its value, and it resumes from that value when counting is enabled again.
- R10: The overflow flag and the counter are zero after reset. The flag is sticky and is cleared only by a pulse on the overflow clear input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 5 | Control write data (bit 0 enable, 1 div64, 2 long, 3 halt, 4 clear) |
| ctl_rdata | output | 5 | Control register readback; bit 4 is always 0 |
| cnt_en_i | input | 1 | Per-counter enable |
| prohibit_i | input | 1 | External counting-prohibited condition |
| freeze_i | input | 1 | Event-counting-frozen condition |
| ovf_clr_i | input | 1 | Overflow flag clear strobe |
| count_o | output | CNT_W | Counter value |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
On every cycle the assertions check three properties. The counter only ever holds, steps by one, or goes to zero on a clear write. It holds whenever the enables or the halt condition forbid counting. In long mode it steps on every enabled clock. They also check that the flag stays set until a clear pulse, and that it only rises when the lower bits have just wrapped to zero. The bench scenarios are what show the actual 64-clock prescale period. They also show that the divider is retained across a disable and cleared by the clear bit, and that the correct wrap point applies in each mode. The bench builds the counter with a narrow width so that the full wrap can be reached.

// File: rtl/cycle_tally_pkg.sv
package cycle_tally_pkg;
  localparam int CTL_W    = 5;
  localparam int BIT_EN   = 0;
  localparam int BIT_DIV  = 1;
  localparam int BIT_LONG = 2;
  localparam int BIT_HALT = 3;
  localparam int BIT_CLR  = 4;
  localparam logic [CTL_W-1:0] STORE_MASK = ~(CTL_W'(1) << BIT_CLR);
endpackage

// File: rtl/ct_ctlreg.sv
module ct_ctlreg
  import cycle_tally_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             wr,
  input  logic [CTL_W-1:0] wdata,
  output logic [CTL_W-1:0] cfg_q,
  output logic             clr_pulse
);
  // The clear bit acts on the write edge and is never stored.
  assign clr_pulse = wr & wdata[BIT_CLR];

  always_ff @(posedge clk) begin
    if (rst)     cfg_q <= '0;
    else if (wr) cfg_q <= wdata & STORE_MASK;
  end

  assert_clr_reads_zero_R6: assert property (@(posedge clk) disable iff (rst)
    wr |=> cfg_q[BIT_CLR] == 1'b0);
endmodule

// File: rtl/ct_gate.sv
module ct_gate
  import cycle_tally_pkg::*;
(
  input  logic [CTL_W-1:0] cfg,
  input  logic             cnt_en,
  input  logic             prohibit,
  input  logic             freeze,
  output logic             run
);
  logic halted;
  always_comb begin
    halted = cfg[BIT_HALT] & (prohibit | freeze);
    run    = cfg[BIT_EN] & cnt_en & ~halted;
  end
endmodule

// File: rtl/ct_prescale.sv
module ct_prescale #(
  parameter int DIV_W = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic run,
  input  logic active,
  output logic tick
);
  logic [DIV_W-1:0] div_q;

  always_comb tick = run & (~active | (&div_q));

  always_ff @(posedge clk) begin
    if (rst || clr)          div_q <= '0;
    else if (run && active)  div_q <= div_q + DIV_W'(1);
  end

  assert_div_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (!run && !clr) |=> $stable(div_q));
endmodule

// File: rtl/ct_count.sv
module ct_count #(
  parameter int CNT_W   = 64,
  parameter int SHORT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             tick,
  input  logic             long_mode,
  input  logic             ovf_clr,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_q
);
  logic low_full, all_full, wrap;

  always_comb begin
    low_full = &count_q[SHORT_W-1:0];
    all_full = &count_q;
    wrap     = tick & ~clr & (long_mode ? all_full : low_full);
  end

  always_ff @(posedge clk) begin
    if (rst)       count_q <= '0;
    else if (clr)  count_q <= '0;
    else if (tick) count_q <= count_q + CNT_W'(1);
  end

  // Setting wins over a simultaneous clear strobe.
  always_ff @(posedge clk) begin
    if (rst)          ovf_q <= 1'b0;
    else if (wrap)    ovf_q <= 1'b1;
    else if (ovf_clr) ovf_q <= 1'b0;
  end

  assert_step_one_R1: assert property (@(posedge clk) disable iff (rst)
    !clr |=> (count_q == $past(count_q)) || (count_q == $past(count_q) + CNT_W'(1)));
  assert_clear_zero_R6: assert property (@(posedge clk) disable iff (rst)
    clr |=> count_q == '0);
  assert_ovf_sticky_R10: assert property (@(posedge clk) disable iff (rst)
    (ovf_q && !ovf_clr) |=> ovf_q);
  assert_ovf_at_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_q) |-> count_q[SHORT_W-1:0] == '0);
endmodule

// File: rtl/cycle_tally.sv
module cycle_tally
  import cycle_tally_pkg::*;
#(
  parameter int CNT_W   = 64,
  parameter int SHORT_W = 32,
  parameter int DIV_W   = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [CTL_W-1:0] ctl_rdata,
  input  logic             cnt_en_i,
  input  logic             prohibit_i,
  input  logic             freeze_i,
  input  logic             ovf_clr_i,
  output logic [CNT_W-1:0] count_o,
  output logic             ovf_o
);
  logic [CTL_W-1:0] cfg_q;
  logic clr_w, run_w, tick_w, presc_on;

  ct_ctlreg u_ctl (
    .clk(clk), .rst(rst), .wr(ctl_wr), .wdata(ctl_wdata),
    .cfg_q(cfg_q), .clr_pulse(clr_w)
  );

  ct_gate u_gate (
    .cfg(cfg_q), .cnt_en(cnt_en_i), .prohibit(prohibit_i),
    .freeze(freeze_i), .run(run_w)
  );

  // Long mode forces the prescaler off.
  assign presc_on = cfg_q[BIT_DIV] & ~cfg_q[BIT_LONG];

  ct_prescale #(.DIV_W(DIV_W)) u_pre (
    .clk(clk), .rst(rst), .clr(clr_w), .run(run_w),
    .active(presc_on), .tick(tick_w)
  );

  ct_count #(.CNT_W(CNT_W), .SHORT_W(SHORT_W)) u_cnt (
    .clk(clk), .rst(rst), .clr(clr_w), .tick(tick_w),
    .long_mode(cfg_q[BIT_LONG]), .ovf_clr(ovf_clr_i),
    .count_q(count_o), .ovf_q(ovf_o)
  );

  assign ctl_rdata = cfg_q;

  assert_hold_disabled_R8: assert property (@(posedge clk) disable iff (rst)
    (!(cfg_q[BIT_EN] && cnt_en_i) && !clr_w) |=> $stable(count_o));
  assert_hold_halted_R7: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[BIT_HALT] && (prohibit_i || freeze_i) && !clr_w) |=> $stable(count_o));
  assert_long_every_clk_R3: assert property (@(posedge clk) disable iff (rst)
    (cfg_q[BIT_EN] && cnt_en_i && cfg_q[BIT_LONG] && !cfg_q[BIT_HALT] && !clr_w)
      |=> count_o == $past(count_o) + CNT_W'(1));
endmodule

// File: tb/test_cycle_tally.sv
module test_cycle_tally;
  localparam int CW = 12;
  localparam int SW = 6;
  localparam logic [4:0] EN = 5'b00001, DV = 5'b00010, LG = 5'b00100,
                         HT = 5'b01000, RS = 5'b10000;

  logic clk = 1'b0, rst = 1'b1;
  logic ctl_wr = 1'b0;
  logic [4:0] ctl_wdata = '0, ctl_rdata;
  logic cnt_en_i = 1'b0, prohibit_i = 1'b0, freeze_i = 1'b0, ovf_clr_i = 1'b0;
  logic [CW-1:0] count_o;
  logic ovf_o;
  int n_chk = 0, n_bad = 0;

  always #2 clk = ~clk;

  cycle_tally #(.CNT_W(CW), .SHORT_W(SW)) i_cycle_tally (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .cnt_en_i(cnt_en_i), .prohibit_i(prohibit_i),
    .freeze_i(freeze_i), .ovf_clr_i(ovf_clr_i), .count_o(count_o), .ovf_o(ovf_o)
  );

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr_ctl(input logic [4:0] d);
    @(negedge clk); ctl_wr = 1'b1; ctl_wdata = d;
    @(negedge clk); ctl_wr = 1'b0; ctl_wdata = '0;
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_ovf_clr();
    @(negedge clk); ovf_clr_i = 1'b1;
    @(negedge clk); ovf_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    chk("R10 count after reset", count_o, 0);
    chk("R10 ovf after reset", ovf_o, 0);
    chk("R10 ctl after reset", ctl_rdata, 0);
  endtask

  task automatic t_enables();
    cnt_en_i = 1'b1; wr_ctl(RS); step(10);
    chk("R8 global enable off", count_o, 0);
    cnt_en_i = 1'b0; wr_ctl(EN); step(10);
    chk("R8 counter enable off", count_o, 0);
    cnt_en_i = 1'b1; step(5);
    chk("R8 both enables on", count_o, 5);
  endtask

  task automatic t_every();
    wr_ctl(EN | RS); step(17);
    chk("R1 every clock", count_o, 17);
  endtask

  task automatic t_div();
    wr_ctl(EN | DV | RS); step(63);
    chk("R2 before 64th clock", count_o, 0);
    step(1);  chk("R2 at 64th clock", count_o, 1);
    step(64); chk("R2 at 128th clock", count_o, 2);
  endtask

  task automatic t_long_div();
    wr_ctl(EN | DV | LG | RS); step(10);
    chk("R3 long ignores divider", count_o, 10);
  endtask

  task automatic t_hold();
    wr_ctl(EN | DV | RS); step(40);
    cnt_en_i = 1'b0; step(20);
    cnt_en_i = 1'b1; step(23);
    chk("R9 divider kept, before tick", count_o, 0);
    step(1);
    chk("R9 divider kept, tick", count_o, 1);
  endtask

  task automatic t_divclr();
    wr_ctl(EN | DV | RS); step(40);
    wr_ctl(EN | DV | RS);
    chk("R6 clear zeroes count", count_o, 0);
    step(63); chk("R6 divider cleared, before tick", count_o, 0);
    step(1);  chk("R6 divider cleared, tick", count_o, 1);
  endtask

  task automatic t_gate();
    prohibit_i = 1'b1; wr_ctl(EN | HT | RS); step(10);
    chk("R7 halted by prohibit", count_o, 0);
    prohibit_i = 1'b0; freeze_i = 1'b1; step(10);
    chk("R7 halted by freeze", count_o, 0);
    freeze_i = 1'b0; step(5);
    chk("R7 resumes", count_o, 5);
    prohibit_i = 1'b1; freeze_i = 1'b1; wr_ctl(EN | RS); step(7);
    chk("R7 no effect when halt bit clear", count_o, 7);
    prohibit_i = 1'b0; freeze_i = 1'b0;
  endtask

  task automatic t_short_ovf();
    wr_ctl(EN | RS); step(63);
    chk("R4 no ovf before low wrap", ovf_o, 0);
    chk("R4 count before low wrap", count_o, 63);
    step(1);
    chk("R4 ovf at low wrap", ovf_o, 1);
    chk("R4 count at low wrap", count_o, 64);
    step(5);
    chk("R10 ovf sticky", ovf_o, 1);
    pulse_ovf_clr();
    chk("R10 ovf cleared by strobe", ovf_o, 0);
  endtask

  task automatic t_clear_keeps_ovf();
    wr_ctl(EN | RS); step(64);
    chk("R6 ovf set for test", ovf_o, 1);
    wr_ctl(EN | DV | HT | RS);
    chk("R6 count cleared", count_o, 0);
    chk("R6 ovf unchanged by clear", ovf_o, 1);
    chk("R6 readback clear bit zero", ctl_rdata, EN | DV | HT);
    pulse_ovf_clr();
    chk("R10 ovf cleared again", ovf_o, 0);
  endtask

  task automatic t_long_ovf();
    wr_ctl(EN | LG | RS); step(64);
    chk("R5 low wrap ignored", ovf_o, 0);
    chk("R5 count past low wrap", count_o, 64);
    step(4095 - 64);
    chk("R5 count at all ones", count_o, 4095);
    chk("R5 no ovf before full wrap", ovf_o, 0);
    step(1);
    chk("R5 count wrapped", count_o, 0);
    chk("R5 ovf at full wrap", ovf_o, 1);
  endtask

  initial begin
    step(3);
    rst = 1'b0;
    step(1);
    t_reset();
    t_enables();
    t_every();
    t_div();
    t_long_div();
    t_hold();
    t_divclr();
    t_gate();
    t_short_ovf();
    t_clear_keeps_ovf();
    t_long_ovf();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule